// File: doc/BRIEF.md
# MSI Interrupt Translation Table Engine

The engine turns a message-signalled interrupt, named by a (DeviceID, EventID) pair, into a physical interrupt ID and a target redistributor. It does this through three chained on-chip tables. A device table records whether each DeviceID is mapped and how many EventID bits it may use. An event table, with one slice per device, records a collection ID and a physical interrupt ID for each event. A collection table maps each collection ID to a redistributor target. Software fills the tables by pushing 3-doubleword commands into a command stream. The same stream carries refresh (invalidate), synchronisation and software-inject commands.

Translations arrive on their own valid/ready request port and leave on a valid/ready response port. The request side follows a one-entry skid rule: `req_ready` is high whenever the response register is empty or is being drained in the same cycle. A stalled response holds its contents until `rsp_ready` is asserted. The command side accepts one command per cycle while `cmd_ready` is high. `cmd_ready` falls only when the engine has stalled. Refresh, sync and inject results are one-cycle pulses with no handshake.

Top module: `itt_engine`

## Requirements
- R1: A request whose device, event and collection are all mapped returns `rsp_fault`=0 together with the stored interrupt ID and the collection's target. The response is valid in the cycle after the request is accepted.
- R2: A request returns `rsp_fault`=1 with interrupt ID and target both zero in any of these cases: the device is unmapped, the DeviceID is at or above 2^DEV_W, the EventID is at or above 2^(stored width), the event is unmapped, or the collection is unmapped.
- R3: Opcode 0x08 in dw0[7:0] maps the device. The DeviceID is in dw0[63:32], dw1[4:0] holds the EventID width minus one, and dw2[63]=1 maps the device while dw2[63]=0 unmaps it. The command always clears every event entry of that device.
- R4: Opcode 0x09 maps a collection. dw2[15:0] holds the collection ID, dw2[63] is the valid flag, and dw2[16+TGT_W-1:16] is the target.
- R5: Opcode 0x0A maps an event on a mapped device. The EventID is in dw1[31:0], the interrupt ID in dw1[63:32] and the collection ID in dw2[15:0]. The collection need not be mapped yet.
- R6: Opcode 0x01 rewrites only the collection ID (dw2[15:0]) of an existing event. The interrupt ID is kept.
- R7: Opcode 0x0C (device and event, as in R5) pulses `rfs_valid` with `rfs_all`=0 and `rfs_id` = the event's interrupt ID. Opcode 0x0D pulses `rfs_valid` with `rfs_all`=1 and `rfs_id` = the collection ID from dw2[15:0]. Both pulses come one cycle after acceptance.
- R8: Opcode 0x05 pulses `sync_valid` with `sync_target` = dw2[16+TGT_W-1:16], one cycle after acceptance.
- R9: Opcode 0x03 (device and event) pulses `inj_valid` with the translated interrupt ID and target when the translation hits. On a miss it raises `stalled` instead, and `cmd_ready` stays low until reset.
- R10: An unknown opcode, or a command with illegal fields, changes no table and sets the sticky `err_flag`. A width field above EVT_W-1 in a map-device command is such an illegal field.
- R11: A request accepted in the same cycle as a table-changing command sees the complete old entry.
- R12: While `rsp_valid`=1 and `rsp_ready`=0, the response holds stable and `req_ready`=0.
- R13: Reset clears every table, `err_flag`, `stalled`, all pulses and `rsp_valid`. After reset `cmd_ready` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | command present |
| cmd_ready | output | 1 | command accepted when high with valid |
| cmd_dw0 | input | 64 | opcode and DeviceID |
| cmd_dw1 | input | 64 | EventID, interrupt ID or width field |
| cmd_dw2 | input | 64 | collection ID, target, valid flag |
| req_valid | input | 1 | translation request present |
| req_ready | output | 1 | translation request accepted |
| req_dev | input | 32 | DeviceID to translate |
| req_evt | input | 32 | EventID to translate |
| rsp_valid | output | 1 | translation result present |
| rsp_ready | input | 1 | consumer takes result |
| rsp_fault | output | 1 | translation missed |
| rsp_intid | output | INTID_W | physical interrupt ID |
| rsp_target | output | TGT_W | redistributor target |
| rfs_valid | output | 1 | refresh request pulse |
| rfs_all | output | 1 | refresh covers a whole collection |
| rfs_id | output | INTID_W | interrupt ID or collection ID |
| inj_valid | output | 1 | software-injected interrupt pulse |
| inj_intid | output | INTID_W | injected interrupt ID |
| inj_target | output | TGT_W | injected interrupt target |
| sync_valid | output | 1 | sync completion pulse |
| sync_target | output | TGT_W | target named by the sync |
| err_flag | output | 1 | sticky command error |
| stalled | output | 1 | command stream halted by a failed inject |

## Verification
A translation result appears one cycle after the request handshake, since there is a single response register. Table writes, refresh, sync and inject pulses, and flag changes all take effect at the edge where a command is accepted, and the pulses are readable for exactly the following cycle. The bench drives inputs on falling edges. It samples every result at the falling edge right after the accepting rising edge, so each check reads the cycle its result is due in. The back-pressure and same-cycle-update cases hold or align both handshakes on purpose and sample over several falling edges.

// File: rtl/itt_pkg.sv
package itt_pkg;
  typedef enum logic [7:0] {
    OP_MOVE   = 8'h01,
    OP_INJECT = 8'h03,
    OP_SYNC   = 8'h05,
    OP_MAPDEV = 8'h08,
    OP_MAPCOL = 8'h09,
    OP_MAPEVT = 8'h0A,
    OP_INV    = 8'h0C,
    OP_INVALL = 8'h0D
  } opcode_e;

  typedef enum logic [2:0] {
    UPD_NONE,
    UPD_DEV,
    UPD_COL,
    UPD_EVT,
    UPD_MOVE
  } upd_kind_e;
endpackage

// File: rtl/itt_lookup.sv
// Chained device -> event -> collection lookup, purely combinational.
module itt_lookup #(
  parameter int DEV_W   = 3,
  parameter int EVT_W   = 4,
  parameter int COL_W   = 2,
  parameter int INTID_W = 16,
  parameter int TGT_W   = 16,
  localparam int NDEV   = 1 << DEV_W,
  localparam int NEVT   = 1 << EVT_W,
  localparam int NCOL   = 1 << COL_W,
  localparam int NENT   = NDEV * NEVT,
  localparam int BITS_W = $clog2(EVT_W + 1)
) (
  input  logic [31:0]        dev_id,
  input  logic [31:0]        evt_id,
  input  logic [NDEV-1:0]    dev_v,
  input  logic [BITS_W-1:0]  dev_bits [NDEV],
  input  logic [NENT-1:0]    ev_v,
  input  logic [COL_W-1:0]   ev_col [NENT],
  input  logic [INTID_W-1:0] ev_int [NENT],
  input  logic [NCOL-1:0]    col_v,
  input  logic [TGT_W-1:0]   col_tgt [NCOL],
  output logic               dev_hit,
  output logic               evt_ok,
  output logic               evt_hit,
  output logic               col_hit,
  output logic [INTID_W-1:0] intid,
  output logic [TGT_W-1:0]   target
);
  logic [DEV_W-1:0]       d;
  logic [EVT_W-1:0]       e;
  logic [DEV_W+EVT_W-1:0] idx;
  logic [COL_W-1:0]       col;
  logic                   dev_in;
  logic                   evt_in;

  assign d      = dev_id[DEV_W-1:0];
  assign e      = evt_id[EVT_W-1:0];
  assign idx    = {d, e};
  assign dev_in = (dev_id >> DEV_W) == 32'd0;
  assign evt_in = (evt_id >> dev_bits[d]) == 32'd0;

  assign dev_hit = dev_in && dev_v[d];
  assign evt_ok  = dev_hit && evt_in;
  assign evt_hit = evt_ok && ev_v[idx];
  assign col     = ev_col[idx];
  assign col_hit = evt_hit && col_v[col];
  assign intid   = ev_int[idx];
  assign target  = col_tgt[col];
endmodule

// File: rtl/itt_tables.sv
// Storage for the three tables, one update port and NPORT lookup ports.
module itt_tables
  import itt_pkg::*;
#(
  parameter int DEV_W   = 3,
  parameter int EVT_W   = 4,
  parameter int COL_W   = 2,
  parameter int INTID_W = 16,
  parameter int TGT_W   = 16,
  parameter int NPORT   = 2,
  localparam int NDEV   = 1 << DEV_W,
  localparam int NEVT   = 1 << EVT_W,
  localparam int NCOL   = 1 << COL_W,
  localparam int NENT   = NDEV * NEVT,
  localparam int BITS_W = $clog2(EVT_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  upd_kind_e          upd_kind,
  input  logic [DEV_W-1:0]   upd_dev,
  input  logic [EVT_W-1:0]   upd_evt,
  input  logic [COL_W-1:0]   upd_col,
  input  logic [INTID_W-1:0] upd_int,
  input  logic [BITS_W-1:0]  upd_bits,
  input  logic [TGT_W-1:0]   upd_tgt,
  input  logic               upd_valid,
  input  logic [31:0]        q_dev [NPORT],
  input  logic [31:0]        q_evt [NPORT],
  output logic [NPORT-1:0]   q_dev_hit,
  output logic [NPORT-1:0]   q_evt_ok,
  output logic [NPORT-1:0]   q_evt_hit,
  output logic [NPORT-1:0]   q_col_hit,
  output logic [INTID_W-1:0] q_int [NPORT],
  output logic [TGT_W-1:0]   q_tgt [NPORT]
);
  logic [NDEV-1:0]    dev_v;
  logic [BITS_W-1:0]  dev_bits [NDEV];
  logic [NENT-1:0]    ev_v;
  logic [COL_W-1:0]   ev_col [NENT];
  logic [INTID_W-1:0] ev_int [NENT];
  logic [NCOL-1:0]    col_v;
  logic [TGT_W-1:0]   col_tgt [NCOL];

  // valid bits: reset, and cleared per device on every map-device command
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_v <= '0;
      ev_v  <= '0;
      col_v <= '0;
    end else begin
      case (upd_kind)
        UPD_DEV: begin
          dev_v[upd_dev] <= upd_valid;
          for (int i = 0; i < NEVT; i++) ev_v[{upd_dev, EVT_W'(i)}] <= 1'b0;
        end
        UPD_COL: col_v[upd_col] <= upd_valid;
        UPD_EVT: ev_v[{upd_dev, upd_evt}] <= 1'b1;
        default: ;
      endcase
    end
  end

  // payload fields carry no reset: they are only read behind a valid bit
  always_ff @(posedge clk) begin
    case (upd_kind)
      UPD_DEV:  dev_bits[upd_dev] <= upd_bits;
      UPD_COL:  col_tgt[upd_col] <= upd_tgt;
      UPD_EVT: begin
        ev_col[{upd_dev, upd_evt}] <= upd_col;
        ev_int[{upd_dev, upd_evt}] <= upd_int;
      end
      UPD_MOVE: ev_col[{upd_dev, upd_evt}] <= upd_col;
      default: ;
    endcase
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    itt_lookup #(
      .DEV_W(DEV_W), .EVT_W(EVT_W), .COL_W(COL_W),
      .INTID_W(INTID_W), .TGT_W(TGT_W)
    ) u_lk (
      .dev_id  (q_dev[g]),
      .evt_id  (q_evt[g]),
      .dev_v   (dev_v),
      .dev_bits(dev_bits),
      .ev_v    (ev_v),
      .ev_col  (ev_col),
      .ev_int  (ev_int),
      .col_v   (col_v),
      .col_tgt (col_tgt),
      .dev_hit (q_dev_hit[g]),
      .evt_ok  (q_evt_ok[g]),
      .evt_hit (q_evt_hit[g]),
      .col_hit (q_col_hit[g]),
      .intid   (q_int[g]),
      .target  (q_tgt[g])
    );
  end
endmodule

// File: rtl/itt_cmd_exec.sv
// Command decode and execution: one command per cycle, registered pulses.
module itt_cmd_exec
  import itt_pkg::*;
#(
  parameter int DEV_W   = 3,
  parameter int EVT_W   = 4,
  parameter int COL_W   = 2,
  parameter int INTID_W = 16,
  parameter int TGT_W   = 16,
  localparam int BITS_W = $clog2(EVT_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [63:0]        cmd_dw0,
  input  logic [63:0]        cmd_dw1,
  input  logic [63:0]        cmd_dw2,
  output logic [31:0]        lk_dev,
  output logic [31:0]        lk_evt,
  input  logic               lk_evt_ok,
  input  logic               lk_evt_hit,
  input  logic               lk_col_hit,
  input  logic [INTID_W-1:0] lk_int,
  input  logic [TGT_W-1:0]   lk_tgt,
  output upd_kind_e          upd_kind,
  output logic [DEV_W-1:0]   upd_dev,
  output logic [EVT_W-1:0]   upd_evt,
  output logic [COL_W-1:0]   upd_col,
  output logic [INTID_W-1:0] upd_int,
  output logic [BITS_W-1:0]  upd_bits,
  output logic [TGT_W-1:0]   upd_tgt,
  output logic               upd_valid,
  output logic               rfs_valid,
  output logic               rfs_all,
  output logic [INTID_W-1:0] rfs_id,
  output logic               inj_valid,
  output logic [INTID_W-1:0] inj_intid,
  output logic [TGT_W-1:0]   inj_target,
  output logic               sync_valid,
  output logic [TGT_W-1:0]   sync_target,
  output logic               err_flag,
  output logic               stalled
);
  logic              fire;
  logic [7:0]        opcode;
  logic [15:0]       col_field;
  logic              dev_in;
  logic              col_in;
  logic              size_ok;
  logic              unused_bits;
  upd_kind_e         kind;
  logic              bad;
  logic              stall_set;
  logic              rfs_n, rfs_all_n, inj_n, sync_n;
  logic [INTID_W-1:0] rfs_id_n;

  assign cmd_ready   = !stalled;
  assign fire        = cmd_valid && cmd_ready;
  assign opcode      = cmd_dw0[7:0];
  assign lk_dev      = cmd_dw0[63:32];
  assign lk_evt      = cmd_dw1[31:0];
  assign col_field   = cmd_dw2[15:0];
  assign dev_in      = (lk_dev >> DEV_W) == 32'd0;
  assign col_in      = (col_field >> COL_W) == 16'd0;
  assign size_ok     = 32'(cmd_dw1[4:0]) < EVT_W;
  assign unused_bits = ^{cmd_dw0, cmd_dw1, cmd_dw2};

  assign upd_dev   = cmd_dw0[32+DEV_W-1:32];
  assign upd_evt   = cmd_dw1[EVT_W-1:0];
  assign upd_col   = col_field[COL_W-1:0];
  assign upd_int   = cmd_dw1[32+INTID_W-1:32];
  assign upd_bits  = BITS_W'(cmd_dw1[4:0] + 5'd1);
  assign upd_tgt   = cmd_dw2[16+TGT_W-1:16];
  assign upd_valid = cmd_dw2[63];
  assign upd_kind  = fire ? kind : UPD_NONE;

  always_comb begin
    kind      = UPD_NONE;
    bad       = 1'b0;
    stall_set = 1'b0;
    rfs_n     = 1'b0;
    rfs_all_n = 1'b0;
    rfs_id_n  = '0;
    inj_n     = 1'b0;
    sync_n    = 1'b0;
    case (opcode)
      OP_MAPDEV: begin
        if (dev_in && (!upd_valid || size_ok)) kind = UPD_DEV;
        else bad = 1'b1;
      end
      OP_MAPCOL: begin
        if (col_in) kind = UPD_COL;
        else bad = 1'b1;
      end
      OP_MAPEVT: begin
        if (lk_evt_ok && col_in) kind = UPD_EVT;
        else bad = 1'b1;
      end
      OP_MOVE: begin
        if (lk_evt_hit && col_in) kind = UPD_MOVE;
        else bad = 1'b1;
      end
      OP_INV: begin
        if (lk_evt_hit) begin
          rfs_n    = 1'b1;
          rfs_id_n = lk_int;
        end else bad = 1'b1;
      end
      OP_INVALL: begin
        if (col_in) begin
          rfs_n     = 1'b1;
          rfs_all_n = 1'b1;
          rfs_id_n  = {{(INTID_W-COL_W){1'b0}}, upd_col};
        end else bad = 1'b1;
      end
      OP_SYNC:   sync_n = 1'b1;
      OP_INJECT: begin
        if (lk_col_hit) inj_n = 1'b1;
        else stall_set = 1'b1;
      end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rfs_valid   <= 1'b0;
      rfs_all     <= 1'b0;
      rfs_id      <= '0;
      inj_valid   <= 1'b0;
      inj_intid   <= '0;
      inj_target  <= '0;
      sync_valid  <= 1'b0;
      sync_target <= '0;
      err_flag    <= 1'b0;
      stalled     <= 1'b0;
    end else begin
      rfs_valid  <= fire && rfs_n;
      inj_valid  <= fire && inj_n;
      sync_valid <= fire && sync_n;
      if (fire && rfs_n) begin
        rfs_all <= rfs_all_n;
        rfs_id  <= rfs_id_n;
      end
      if (fire && inj_n) begin
        inj_intid  <= lk_int;
        inj_target <= lk_tgt;
      end
      if (fire && sync_n) sync_target <= upd_tgt;
      if (fire && bad) err_flag <= 1'b1;
      if (fire && stall_set) stalled <= 1'b1;
    end
  end
endmodule

// File: rtl/itt_xlate_port.sv
// Translation request/response register with one-entry back-pressure.
module itt_xlate_port #(
  parameter int INTID_W = 16,
  parameter int TGT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               lk_hit,
  input  logic [INTID_W-1:0] lk_int,
  input  logic [TGT_W-1:0]   lk_tgt,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [INTID_W-1:0] rsp_intid,
  output logic [TGT_W-1:0]   rsp_target
);
  logic acc;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_intid  <= '0;
      rsp_target <= '0;
    end else begin
      if (acc) rsp_valid <= 1'b1;
      else if (rsp_ready) rsp_valid <= 1'b0;
      if (acc) begin
        rsp_fault  <= !lk_hit;
        rsp_intid  <= lk_hit ? lk_int : '0;
        rsp_target <= lk_hit ? lk_tgt : '0;
      end
    end
  end
endmodule

// File: rtl/itt_engine.sv
module itt_engine
  import itt_pkg::*;
#(
  parameter int DEV_W   = 3,
  parameter int EVT_W   = 4,
  parameter int COL_W   = 2,
  parameter int INTID_W = 16,
  parameter int TGT_W   = 16,
  localparam int BITS_W = $clog2(EVT_W + 1),
  localparam int NPORT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [63:0]        cmd_dw0,
  input  logic [63:0]        cmd_dw1,
  input  logic [63:0]        cmd_dw2,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_dev,
  input  logic [31:0]        req_evt,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [INTID_W-1:0] rsp_intid,
  output logic [TGT_W-1:0]   rsp_target,
  output logic               rfs_valid,
  output logic               rfs_all,
  output logic [INTID_W-1:0] rfs_id,
  output logic               inj_valid,
  output logic [INTID_W-1:0] inj_intid,
  output logic [TGT_W-1:0]   inj_target,
  output logic               sync_valid,
  output logic [TGT_W-1:0]   sync_target,
  output logic               err_flag,
  output logic               stalled
);
  localparam int PX = 0;  // translation lookup port
  localparam int PC = 1;  // command lookup port

  logic [31:0]        q_dev [NPORT];
  logic [31:0]        q_evt [NPORT];
  logic [NPORT-1:0]   q_dev_hit, q_evt_ok, q_evt_hit, q_col_hit;
  logic [INTID_W-1:0] q_int [NPORT];
  logic [TGT_W-1:0]   q_tgt [NPORT];
  logic [31:0]        c_dev, c_evt;

  upd_kind_e          upd_kind;
  logic [DEV_W-1:0]   upd_dev;
  logic [EVT_W-1:0]   upd_evt;
  logic [COL_W-1:0]   upd_col;
  logic [INTID_W-1:0] upd_int;
  logic [BITS_W-1:0]  upd_bits;
  logic [TGT_W-1:0]   upd_tgt;
  logic               upd_valid;
  logic               unused_hits;

  assign q_dev[PX]   = req_dev;
  assign q_evt[PX]   = req_evt;
  assign q_dev[PC]   = c_dev;
  assign q_evt[PC]   = c_evt;
  assign unused_hits = ^{q_dev_hit, q_evt_ok[PX], q_evt_hit[PX]};

  itt_tables #(
    .DEV_W(DEV_W), .EVT_W(EVT_W), .COL_W(COL_W),
    .INTID_W(INTID_W), .TGT_W(TGT_W), .NPORT(NPORT)
  ) u_tab (
    .clk(clk), .rst_n(rst_n),
    .upd_kind(upd_kind), .upd_dev(upd_dev), .upd_evt(upd_evt),
    .upd_col(upd_col), .upd_int(upd_int), .upd_bits(upd_bits),
    .upd_tgt(upd_tgt), .upd_valid(upd_valid),
    .q_dev(q_dev), .q_evt(q_evt),
    .q_dev_hit(q_dev_hit), .q_evt_ok(q_evt_ok), .q_evt_hit(q_evt_hit),
    .q_col_hit(q_col_hit), .q_int(q_int), .q_tgt(q_tgt)
  );

  itt_cmd_exec #(
    .DEV_W(DEV_W), .EVT_W(EVT_W), .COL_W(COL_W),
    .INTID_W(INTID_W), .TGT_W(TGT_W)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dw0(cmd_dw0), .cmd_dw1(cmd_dw1), .cmd_dw2(cmd_dw2),
    .lk_dev(c_dev), .lk_evt(c_evt),
    .lk_evt_ok(q_evt_ok[PC]), .lk_evt_hit(q_evt_hit[PC]),
    .lk_col_hit(q_col_hit[PC]), .lk_int(q_int[PC]), .lk_tgt(q_tgt[PC]),
    .upd_kind(upd_kind), .upd_dev(upd_dev), .upd_evt(upd_evt),
    .upd_col(upd_col), .upd_int(upd_int), .upd_bits(upd_bits),
    .upd_tgt(upd_tgt), .upd_valid(upd_valid),
    .rfs_valid(rfs_valid), .rfs_all(rfs_all), .rfs_id(rfs_id),
    .inj_valid(inj_valid), .inj_intid(inj_intid), .inj_target(inj_target),
    .sync_valid(sync_valid), .sync_target(sync_target),
    .err_flag(err_flag), .stalled(stalled)
  );

  itt_xlate_port #(.INTID_W(INTID_W), .TGT_W(TGT_W)) u_xp (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .lk_hit(q_col_hit[PX]), .lk_int(q_int[PX]), .lk_tgt(q_tgt[PX]),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_intid(rsp_intid), .rsp_target(rsp_target)
  );
endmodule

// File: rtl/itt_engine_chk.sv
module itt_engine_chk #(
  parameter int INTID_W = 16,
  parameter int TGT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_fault,
  input logic [INTID_W-1:0] rsp_intid,
  input logic [TGT_W-1:0]   rsp_target,
  input logic               rfs_valid,
  input logic               inj_valid,
  input logic               sync_valid,
  input logic               err_flag,
  input logic               stalled
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_intid) && $stable(rsp_target)); // R12
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R12
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_intid == '0 && rsp_target == '0); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> stalled); // R9
  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !cmd_ready); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R10
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rfs_valid, inj_valid, sync_valid})); // R7
endmodule

bind itt_engine itt_engine_chk #(.INTID_W(INTID_W), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_intid(rsp_intid), .rsp_target(rsp_target), .rfs_valid(rfs_valid),
  .inj_valid(inj_valid), .sync_valid(sync_valid), .err_flag(err_flag),
  .stalled(stalled)
);

// File: tb/sim_itt_engine.sv
module sim_itt_engine;
  typedef struct packed {
    logic        is_x;
    logic [63:0] d0;
    logic [63:0] d1;
    logic [63:0] d2;
    logic        fault;
    logic [15:0] intid;
    logic [15:0] tgt;
  } vec_t;

  localparam int NV = 22;
  // is_x=0: command (d0,d1,d2); is_x=1: translate dev=d0, evt=d1, expect fault/intid/tgt
  localparam vec_t VEC [NV] = '{
    '{1'b0, 64'h09, 64'h0, 64'h8000_0000_0002_0001, 1'b0, 16'h0, 16'h0},                 // R4 col1 -> 2
    '{1'b0, 64'h09, 64'h0, 64'h8000_0000_0005_0002, 1'b0, 16'h0, 16'h0},                 // R4 col2 -> 5
    '{1'b0, 64'h0000_0003_0000_0008, 64'h1, 64'h8000_0000_0000_1000, 1'b0, 16'h0, 16'h0}, // R3 dev3, 2 bits
    '{1'b0, 64'h0000_0003_0000_000A, 64'h0000_2002_0000_0002, 64'h1, 1'b0, 16'h0, 16'h0}, // R5
    '{1'b1, 64'd3, 64'd2, 64'h0, 1'b0, 16'h2002, 16'h0002},                             // R1
    '{1'b1, 64'd3, 64'd4, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R2 range
    '{1'b1, 64'd3, 64'd1, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R2 no event
    '{1'b1, 64'd5, 64'd0, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R2 no device
    '{1'b0, 64'h0000_0003_0000_000A, 64'h0000_2003_0000_0003, 64'h3, 1'b0, 16'h0, 16'h0}, // R5 col3 unmapped
    '{1'b1, 64'd3, 64'd3, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R2 no collection
    '{1'b0, 64'h0000_0003_0000_0001, 64'h2, 64'h2, 1'b0, 16'h0, 16'h0},                 // R6 move to col2
    '{1'b1, 64'd3, 64'd2, 64'h0, 1'b0, 16'h2002, 16'h0005},                             // R6
    '{1'b0, 64'h09, 64'h0, 64'h2, 1'b0, 16'h0, 16'h0},                                  // R4 unmap col2
    '{1'b1, 64'd3, 64'd2, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R4
    '{1'b0, 64'h0000_0003_0000_0008, 64'h1, 64'h0, 1'b0, 16'h0, 16'h0},                 // R3 unmap dev3
    '{1'b1, 64'd3, 64'd2, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R3
    '{1'b0, 64'h0000_0003_0000_0008, 64'h3, 64'h8000_0000_0000_2000, 1'b0, 16'h0, 16'h0}, // R3 dev3, 4 bits
    '{1'b1, 64'd3, 64'd2, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R3 events cleared
    '{1'b0, 64'h0000_0003_0000_000A, 64'h0000_0307_0000_0007, 64'h1, 1'b0, 16'h0, 16'h0}, // R5
    '{1'b1, 64'd3, 64'd7, 64'h0, 1'b0, 16'h0307, 16'h0002},                             // R1
    '{1'b1, 64'd3, 64'd8, 64'h0, 1'b1, 16'h0, 16'h0},                                   // R2 new width
    '{1'b1, 64'd11, 64'd7, 64'h0, 1'b1, 16'h0, 16'h0}                                   // R2 dev >= 8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [63:0] cmd_dw0 = '0, cmd_dw1 = '0, cmd_dw2 = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_dev = '0, req_evt = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_fault;
  logic [15:0] rsp_intid, rsp_target;
  logic        rfs_valid, rfs_all;
  logic [15:0] rfs_id;
  logic        inj_valid;
  logic [15:0] inj_intid, inj_target;
  logic        sync_valid;
  logic [15:0] sync_target;
  logic        err_flag, stalled;

  int n_chk = 0;
  int n_fail = 0;
  logic [33:0] r;

  always #5 clk = ~clk;

  itt_engine u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dw0(cmd_dw0), .cmd_dw1(cmd_dw1), .cmd_dw2(cmd_dw2),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev), .req_evt(req_evt),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_intid(rsp_intid), .rsp_target(rsp_target),
    .rfs_valid(rfs_valid), .rfs_all(rfs_all), .rfs_id(rfs_id),
    .inj_valid(inj_valid), .inj_intid(inj_intid), .inj_target(inj_target),
    .sync_valid(sync_valid), .sync_target(sync_target),
    .err_flag(err_flag), .stalled(stalled)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic send_cmd(input logic [63:0] d0, input logic [63:0] d1, input logic [63:0] d2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dw0 = d0; cmd_dw1 = d1; cmd_dw2 = d2;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] dev, input logic [31:0] evt, output logic [33:0] res);
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev; req_evt = evt; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    res = {rsp_valid, rsp_fault, rsp_intid, rsp_target};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    check("R13 cmd_ready after reset", 64'(cmd_ready), 64'd1);
    check("R13 req_ready after reset", 64'(req_ready), 64'd1);
    check("R13 outputs idle after reset",
          64'({rsp_valid, err_flag, stalled, rfs_valid, inj_valid, sync_valid}), 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // table-driven walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_x) begin
        xlate(VEC[i].d0[31:0], VEC[i].d1[31:0], r);
        check($sformatf("R1 R2 R3 R4 R5 R6 table row %0d", i), 64'(r),
              64'({1'b1, VEC[i].fault, VEC[i].intid, VEC[i].tgt}));
      end else begin
        send_cmd(VEC[i].d0, VEC[i].d1, VEC[i].d2);
      end
    end
    check("R10 no error after legal commands", 64'(err_flag), 64'd0);

    // R7 refresh of one event, then of a collection
    send_cmd(64'h0000_0003_0000_000C, 64'd7, 64'd0);
    check("R7 event refresh pulse", 64'({rfs_valid, rfs_all, rfs_id}), 64'({1'b1, 1'b0, 16'h0307}));
    send_cmd(64'h0D, 64'd0, 64'd1);
    check("R7 collection refresh pulse", 64'({rfs_valid, rfs_all, rfs_id}), 64'({1'b1, 1'b1, 16'h0001}));

    // R8 sync
    send_cmd(64'h05, 64'd0, 64'h0000_0000_0009_0000);
    check("R8 sync pulse", 64'({sync_valid, sync_target}), 64'({1'b1, 16'h0009}));
    @(negedge clk);
    check("R8 sync pulse one cycle", 64'(sync_valid), 64'd0);

    // R9 inject on a mapped event
    send_cmd(64'h0000_0003_0000_0003, 64'd7, 64'd0);
    check("R9 inject pulse", 64'({inj_valid, inj_intid, inj_target}), 64'({1'b1, 16'h0307, 16'h0002}));

    // R11 lookup in the same cycle as a collection remap sees the old target
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dw0 = 64'h09; cmd_dw1 = 64'd0; cmd_dw2 = 64'h8000_0000_000A_0001;
    req_valid = 1'b1; req_dev = 32'd3; req_evt = 32'd7; rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; req_valid = 1'b0;
    check("R11 coincident lookup old entry", 64'({rsp_valid, rsp_fault, rsp_intid, rsp_target}),
          64'({1'b1, 1'b0, 16'h0307, 16'h0002}));
    xlate(32'd3, 32'd7, r);
    check("R11 next lookup new entry", 64'(r), 64'({1'b1, 1'b0, 16'h0307, 16'h000A}));

    // R12 back-pressure on the response
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_dev = 32'd3; req_evt = 32'd7;
    @(negedge clk);
    req_evt = 32'd8;
    check("R12 req_ready low while held", 64'(req_ready), 64'd0);
    check("R12 first response", 64'({rsp_valid, rsp_fault, rsp_intid, rsp_target}),
          64'({1'b1, 1'b0, 16'h0307, 16'h000A}));
    @(negedge clk);
    check("R12 response held stable", 64'({rsp_valid, rsp_fault, rsp_intid, rsp_target}),
          64'({1'b1, 1'b0, 16'h0307, 16'h000A}));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 second response after drain", 64'({rsp_valid, rsp_fault, rsp_intid, rsp_target}),
          64'({1'b1, 1'b1, 16'h0, 16'h0}));

    // R10 map-device with width too large
    check("R10 flag clear before bad command", 64'(err_flag), 64'd0);
    send_cmd(64'h0000_0005_0000_0008, 64'd7, 64'h8000_0000_0000_3000);
    check("R10 oversize width sets flag", 64'(err_flag), 64'd1);
    send_cmd(64'h0000_0005_0000_000A, 64'h0000_0555_0000_0000, 64'd1);
    xlate(32'd5, 32'd0, r);
    check("R10 oversize map left device unmapped", 64'(r), 64'({1'b1, 1'b1, 16'h0, 16'h0}));

    // R13 reset clears everything
    do_reset();
    @(negedge clk);
    check_reset_state();
    xlate(32'd3, 32'd7, r);
    check("R13 tables cleared by reset", 64'(r), 64'({1'b1, 1'b1, 16'h0, 16'h0}));

    // R10 unknown opcode
    send_cmd(64'h0000_0003_0000_007F, 64'd7, 64'h8000_0000_0001_0001);
    check("R10 unknown opcode sets flag", 64'(err_flag), 64'd1);
    check("R10 unknown opcode no pulse", 64'({rfs_valid, inj_valid, sync_valid}), 64'd0);

    // R9 inject on an unmapped event stalls the stream
    send_cmd(64'h0000_0003_0000_0003, 64'd7, 64'd0);
    check("R9 no inject on miss", 64'(inj_valid), 64'd0);
    check("R9 stalled on miss", 64'({stalled, cmd_ready}), 64'({1'b1, 1'b0}));
    repeat (3) @(negedge clk);
    check("R9 stall persists", 64'({stalled, cmd_ready}), 64'({1'b1, 1'b0}));

    summary();
    $finish;
  end
endmodule